// File: doc/BRIEF.md
# Enable and PWM Dimming Monitor

This block watches one external line that does two jobs: it turns the LED driver on and it carries the PWM dimming waveform. The line is sampled on the controller's free-running clock. A synchronizer comes first, and the pulse-width and idle timing are measured only after it. The driver is switched on only when a high pulse lasts long enough. It is switched off again when the line stays low for longer than the idle limit. While the driver is on, the block passes the synchronized waveform to the channel current sources as a gated PWM. The average LED current is then the peak current times the duty cycle.

The block also times each complete dimming cycle, from one rising edge to the next. From that it flags a duty cycle outside the usable window. The window depends on the measured dimming rate:
- Fast dimming has a tighter lower limit.
- Slow dimming, with a period at or above a threshold, allows a much smaller duty.
- Both bands share the same upper limit.

All timing constants are given as clock-cycle counts. An integrator derives them from the clock frequency.

Top module: `pwm_dim_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the disabled state: `drv_enable`, `led_pwm` and `duty_oor` are all 0.
- R2: When disabled, the block enables (`drv_enable` = 1) only after the synchronized input has been high for at least `EN_MIN_CYC` consecutive samples. A high pulse shorter than this is ignored and leaves `drv_enable` at 0.
- R3: While enabled, `led_pwm` reproduces the input waveform, so its count of high cycles equals the input's. While disabled, `led_pwm` stays at 0.
- R4: While enabled, a low run of exactly `IDLE_CYC` samples keeps the block enabled. A low run of `IDLE_CYC`+1 samples disables it.
- R5: After a shutdown, a high pulse shorter than `EN_MIN_CYC` does not re-enable the block. A pulse of at least `EN_MIN_CYC` does.
- R6: In the fast band (measured period P < `SLOW_PERIOD_CYC`), `duty_oor` is set when H*1000 < `FAST_LO_PM`*P, where H is the number of high samples. The default `FAST_LO_PM` is 100, which means 10.0 %.
- R7: In the slow band (P >= `SLOW_PERIOD_CYC`), the lower limit is `SLOW_LO_PM` per mille. The default is 10, which means 1.0 %.
- R8: In both bands, `duty_oor` is set when H*1000 > `HI_PM`*P. The default `HI_PM` is 995, which means 99.5 %.
- R9: `duty_oor` is re-evaluated at each rising edge that closes a complete cycle measured while enabled. It is 0 whenever `drv_enable` is 0.
- R10: The input passes through a two-flop synchronizer. A rising edge driven just before clock edge k appears on `led_pwm` after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enpwm_raw | input | 1 | Asynchronous dual-purpose enable / PWM line |
| led_pwm | output | 1 | Gated PWM to the channel current sources |
| drv_enable | output | 1 | Driver enabled flag |
| duty_oor | output | 1 | Last measured duty outside the window for its band |

## Verification
The bound checker enforces four rules on every cycle:
- `led_pwm` and `duty_oor` are never high while the driver is disabled.
- The enable flag only rises while the gated output is high.
- A shutdown is only ever preceded by a low gated output.

The bench's directed scenarios cover the rest. These are the exact width and idle boundaries (one sample either side), the three-edge input latency, the preservation of the high-cycle count, and the duty limits of each band at their exact thresholds.

// File: rtl/pwmmon_pkg.sv
package pwmmon_pkg;

    // Scale used for all duty limits: parts per thousand.
    localparam int unsigned PERMILLE = 1000;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } en_state_e;

endpackage

// File: rtl/pwmmon_sync.sv
module pwmmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/pwmmon_enable.sv
module pwmmon_enable
    import pwmmon_pkg::*;
#(
    parameter int unsigned EN_MIN_CYC = 4000,
    parameter int unsigned IDLE_CYC   = 2800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic en_next_o,
    output logic enable_o,
    output logic pwm_o
);

    localparam int unsigned CNT_MAX = (EN_MIN_CYC > IDLE_CYC) ? EN_MIN_CYC : IDLE_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] QUAL_LAST = CW'(EN_MIN_CYC - 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC);

    typedef struct packed {
        en_state_e     state;
        logic [CW-1:0] cnt;
        logic          en;
        logic          pwm;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                st_d.en = 1'b0;
                if (lvl_i) begin
                    if (st_q.cnt == QUAL_LAST) begin
                        st_d.state = ST_RUN;
                        st_d.en    = 1'b1;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    st_d.cnt = '0;
                end
            end
            ST_RUN: begin
                if (lvl_i) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == IDLE_LAST) begin
                    st_d.state = ST_IDLE;
                    st_d.en    = 1'b0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
        st_d.pwm = st_d.en & lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cnt: '0, en: 1'b0, pwm: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_next_o = st_d.en;
    assign enable_o  = st_q.en;
    assign pwm_o     = st_q.pwm;

endmodule

// File: rtl/pwmmon_duty.sv
module pwmmon_duty
    import pwmmon_pkg::*;
#(
    parameter int unsigned MEAS_W          = 24,
    parameter int unsigned SLOW_PERIOD_CYC = 20000,
    parameter int unsigned FAST_LO_PM      = 100,
    parameter int unsigned SLOW_LO_PM      = 10,
    parameter int unsigned HI_PM           = 995
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic active_i,
    output logic oor_o
);

    localparam int unsigned PW = MEAS_W + 11;
    localparam logic [MEAS_W-1:0] SAT      = '1;
    localparam logic [MEAS_W-1:0] SLOW_LIM = MEAS_W'(SLOW_PERIOD_CYC);

    typedef struct packed {
        logic              prev;
        logic              armed;
        logic [MEAS_W-1:0] per;
        logic [MEAS_W-1:0] hi;
        logic              oor;
    } duty_state_t;

    duty_state_t st_d, st_q;

    logic          rise;
    logic          slow_band;
    logic [PW-1:0] lo_pm;
    logic [PW-1:0] hi_scaled;
    logic [PW-1:0] lo_bound;
    logic [PW-1:0] hi_bound;
    logic          verdict;

    always_comb begin
        rise      = lvl_i & ~st_q.prev;
        slow_band = (st_q.per >= SLOW_LIM);
        lo_pm     = slow_band ? PW'(SLOW_LO_PM) : PW'(FAST_LO_PM);
        hi_scaled = PW'(st_q.hi) * PW'(PERMILLE);
        lo_bound  = lo_pm * PW'(st_q.per);
        hi_bound  = PW'(HI_PM) * PW'(st_q.per);
        verdict   = (hi_scaled < lo_bound) || (hi_scaled > hi_bound);

        st_d      = st_q;
        st_d.prev = lvl_i;
        if (!active_i) begin
            st_d.armed = 1'b0;
            st_d.oor   = 1'b0;
            st_d.per   = '0;
            st_d.hi    = '0;
        end else if (rise) begin
            if (st_q.armed) begin
                st_d.oor = verdict;
            end
            st_d.armed = 1'b1;
            st_d.per   = MEAS_W'(1);
            st_d.hi    = MEAS_W'(1);
        end else begin
            if (st_q.per != SAT) begin
                st_d.per = st_q.per + 1'b1;
            end
            if (lvl_i && (st_q.hi != SAT)) begin
                st_d.hi = st_q.hi + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oor_o = st_q.oor;

endmodule

// File: rtl/pwm_dim_monitor.sv
module pwm_dim_monitor
    import pwmmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned EN_MIN_CYC      = 4000,
    parameter int unsigned IDLE_CYC        = 2800000,
    parameter int unsigned SLOW_PERIOD_CYC = 20000,
    parameter int unsigned FAST_LO_PM      = 100,
    parameter int unsigned SLOW_LO_PM      = 10,
    parameter int unsigned HI_PM           = 995
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enpwm_raw,
    output logic led_pwm,
    output logic drv_enable,
    output logic duty_oor
);

    localparam int unsigned SPAN   = (IDLE_CYC > SLOW_PERIOD_CYC) ? IDLE_CYC : SLOW_PERIOD_CYC;
    localparam int unsigned MEAS_W = $clog2(SPAN + 1) + 2;

    logic lvl_s;
    logic en_next;

    pwmmon_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (enpwm_raw),
        .sync_o  (lvl_s)
    );

    pwmmon_enable #(
        .EN_MIN_CYC (EN_MIN_CYC),
        .IDLE_CYC   (IDLE_CYC)
    ) enable_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl_s),
        .en_next_o (en_next),
        .enable_o  (drv_enable),
        .pwm_o     (led_pwm)
    );

    pwmmon_duty #(
        .MEAS_W          (MEAS_W),
        .SLOW_PERIOD_CYC (SLOW_PERIOD_CYC),
        .FAST_LO_PM      (FAST_LO_PM),
        .SLOW_LO_PM      (SLOW_LO_PM),
        .HI_PM           (HI_PM)
    ) duty_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl_s),
        .active_i (en_next),
        .oor_o    (duty_oor)
    );

endmodule

// File: rtl/pwm_dim_monitor_chk.sv
module pwm_dim_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic led_pwm,
    input logic drv_enable,
    input logic duty_oor
);

    // R3
    pwm_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_pwm |-> drv_enable);

    // R9
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_oor |-> drv_enable);

    // R2
    enable_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_enable) |-> led_pwm);

    // R4
    shutdown_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_enable) |-> $past(!led_pwm));

endmodule

bind pwm_dim_monitor pwm_dim_monitor_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .led_pwm    (led_pwm),
    .drv_enable (drv_enable),
    .duty_oor   (duty_oor)
);

// File: tb/pwm_dim_monitor_tb_top.sv
module pwm_dim_monitor_tb_top;

    localparam int EN_MIN = 40;
    localparam int IDLE   = 3000;
    localparam int SLOWP  = 1000;

    logic clk = 1'b0;
    logic rst_n;
    logic enpwm_raw;
    logic led_pwm;
    logic drv_enable;
    logic duty_oor;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pwm_dim_monitor #(
        .EN_MIN_CYC      (EN_MIN),
        .IDLE_CYC        (IDLE),
        .SLOW_PERIOD_CYC (SLOWP)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enpwm_raw  (enpwm_raw),
        .led_pwm    (led_pwm),
        .drv_enable (drv_enable),
        .duty_oor   (duty_oor)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a level for n cycles; starts and ends at a falling edge.
    task automatic hold(input logic v, input int n, inout int pwm_hi);
        enpwm_raw = v;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pwm_hi += int'(led_pwm);
        end
    endtask

    task automatic periods(input int h, input int p, input int reps);
        int dummy = 0;
        for (int i = 0; i < reps; i++) begin
            hold(1'b1, h, dummy);
            hold(1'b0, p - h, dummy);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        enpwm_raw = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 enable in reset", int'(drv_enable), 0);
        check("R1 pwm in reset", int'(led_pwm), 0);
        check("R1 flag in reset", int'(duty_oor), 0);
        enpwm_raw = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_short_pulse();
        int hi = 0;
        hold(1'b1, EN_MIN - 1, hi);
        hold(1'b0, 10, hi);
        check("R2 short pulse ignored", int'(drv_enable), 0);
        check("R3 no pwm while disabled", hi, 0);
    endtask

    task automatic t_enable();
        int hi = 0;
        hold(1'b1, EN_MIN, hi);
        hold(1'b0, 10, hi);
        check("R2 qualifying pulse enables", int'(drv_enable), 1);
    endtask

    task automatic t_latency();
        int hi = 0;
        hold(1'b0, 10, hi);
        enpwm_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 pwm low after two edges", int'(led_pwm), 0);
        @(negedge clk);
        check("R10 pwm high after third edge", int'(led_pwm), 1);
        hold(1'b1, 5, hi);
        hold(1'b0, 10, hi);
    endtask

    task automatic t_follow();
        int hi = 0;
        for (int i = 0; i < 10; i++) begin
            hold(1'b1, 7, hi);
            hold(1'b0, 13, hi);
        end
        hold(1'b0, 5, hi);
        check("R3 pwm high count", hi, 70);
    endtask

    task automatic t_duty(input string req, input int h, input int p, input int exp);
        periods(h, p, 3);
        check(req, int'(duty_oor), exp);
    endtask

    task automatic t_flag_clear();
        int hi = 0;
        periods(9, 100, 3);
        check("R9 flag set before shutdown", int'(duty_oor), 1);
        hold(1'b0, IDLE + 10, hi);
        check("R9 flag cleared on shutdown", int'(duty_oor), 0);
        check("R4 disabled after long idle", int'(drv_enable), 0);
    endtask

    task automatic t_idle();
        int hi = 0;
        hold(1'b1, EN_MIN + 5, hi);
        hold(1'b0, IDLE, hi);
        hold(1'b1, 5, hi);
        check("R4 idle of exactly limit keeps enable", int'(drv_enable), 1);
        hold(1'b0, IDLE + 1, hi);
        hi = 0;
        hold(1'b1, 3, hi);
        hold(1'b0, 5, hi);
        check("R4 idle one past limit disables", int'(drv_enable), 0);
        check("R4 pwm gated after shutdown", hi, 0);
    endtask

    task automatic t_reenable();
        int hi = 0;
        hold(1'b1, EN_MIN - 1, hi);
        hold(1'b0, 10, hi);
        check("R5 short pulse after shutdown ignored", int'(drv_enable), 0);
        hold(1'b1, EN_MIN, hi);
        hold(1'b0, 10, hi);
        check("R5 qualifying pulse re-enables", int'(drv_enable), 1);
    endtask

    initial begin
        t_reset();
        t_short_pulse();
        t_enable();
        t_latency();
        t_follow();
        t_duty("R6 fast 9pct flagged", 9, 100, 1);
        t_duty("R6 fast 10pct accepted", 10, 100, 0);
        t_duty("R6 fast 50pct accepted", 50, 100, 0);
        t_duty("R7 slow 0.95pct flagged", 19, 2000, 1);
        t_duty("R7 slow 1pct accepted", 20, 2000, 0);
        t_duty("R7 slow 5pct accepted", 100, 2000, 0);
        t_duty("R8 fast 99.75pct flagged", 399, 400, 1);
        t_duty("R8 fast 99.5pct accepted", 398, 400, 0);
        t_duty("R8 slow 99.55pct flagged", 1991, 2000, 1);
        t_duty("R8 slow 99.5pct accepted", 1990, 2000, 0);
        t_flag_clear();
        t_reenable();
        t_idle();
        t_reenable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule